// File: doc/BRIEF.md
# Interlocked Peripheral Command Controller

This block carries one output command from a host to a remote peripheral driver and returns completion as an interrupt. It has two controllers that each run on their own clock and reset. The initiator side accepts a host write strobe with a command byte. It latches the byte, raises a request wire toward the target side, and waits. The target side detects the request and fires the latched byte as a one-clock strobe on the peripheral command lines. Only after that does it raise its response.

The exchange is a fully interlocked four-phase handshake. The initiator drops its request when it sees the response. The target drops its response when it sees the request fall. Each wire passes through a two-flop synchronizer before the other side uses it. No step depends on a fixed delay.

When the response has fallen, the initiator raises a latched interrupt and sets a done flag in its status word. Both stay set until the host issues a sense strobe with the reset bit asserted. A write that arrives while a transaction is still in flight is dropped and recorded in a reject flag.

Top module: `pcmd_link`

## Requirements
- R1: After reset, link_req, link_ack, dev_irq, perif_cmd and the whole of dev_status are zero.
- R2: In the idle state, a host_wr strobe latches host_wr_data into dev_status[7:0] and raises link_req on the next clock. While the transaction is in flight, dev_status[13] (busy) reads 1, and link_req stays high until the synchronized link_ack has been seen high.
- R3: Each accepted write produces exactly one perif_cmd pulse. The pulse lasts one clock, carries the written byte, and occurs while link_ack is still low; link_ack rises only after it.
- R4: The initiator lowers link_req after it sees link_ack high, while link_ack is still high. The target keeps link_ack high until it sees link_req low.
- R5: When the initiator sees link_ack fall, the transaction completes. dev_irq goes to 1, dev_status[15] (done) goes to 1, and busy returns to 0.
- R6: A host_sense strobe with host_sense_rst=1 clears dev_irq, done and dev_status[14] (reject). A host_sense strobe with host_sense_rst=0 changes none of them.
- R7: A host_wr that arrives while busy is 1 is ignored: it causes no extra perif_cmd pulse and leaves dev_status[7:0] unchanged. It sets reject to 1.
- R8: When a set condition and a sense-with-reset fall in the same clock, the set wins. This covers a completion together with a sense-with-reset (dev_irq and done end at 1), and a busy write together with a sense-with-reset (reject ends at 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mst_clk | input | 1 | Initiator-side clock |
| mst_arst_n | input | 1 | Initiator-side asynchronous active-low reset |
| slv_clk | input | 1 | Target-side clock |
| slv_arst_n | input | 1 | Target-side asynchronous active-low reset |
| host_wr | input | 1 | Host output-write strobe, one clock |
| host_wr_data | input | 8 | Command byte for the write |
| host_sense | input | 1 | Host sense strobe, one clock |
| host_sense_rst | input | 1 | Reset bit that qualifies host_sense |
| dev_status | output | 16 | Status word: [15] done, [14] reject, [13] busy, [7:0] command |
| dev_irq | output | 1 | Latched completion interrupt |
| link_req | output | 1 | Transaction request from initiator to target |
| link_ack | output | 1 | Response from target to initiator |
| perif_cmd | output | 8 | One-clock command strobe lines to the peripheral interface |

## Verification
A clear from the host can land in the same clock as an internal set. There are two such collisions. In the first, the completion that raises the interrupt and done meets a sense-with-reset. The bench watches link_ack fall and counts the two synchronizer stages plus the initiator register to find the completion clock, then pulses the sense strobe in exactly that clock. It then expects dev_irq and done to read 1. In the second, a write rejected as busy meets a sense-with-reset in the same clock. The bench drives both strobes together mid-transaction and expects reject set while the interrupt is cleared.

// File: rtl/pcmd_pkg.sv
package pcmd_pkg;
  localparam int STAT_W  = 16;
  localparam int ST_DONE = 15;
  localparam int ST_REJ  = 14;
  localparam int ST_BUSY = 13;

  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_REQ  = 2'd1,
    M_DROP = 2'd2
  } mst_state_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_FIRE = 2'd1,
    S_ACK  = 2'd2
  } slv_state_e;
endpackage

// File: rtl/pcmd_rst_sync.sv
module pcmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pcmd_sync2.sv
module pcmd_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pcmd_master.sv
module pcmd_master
  import pcmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DW-1:0]     wr_data,
  input  logic              sense_stb,
  input  logic              sense_rst,
  input  logic              ack_s,
  output logic              req,
  output logic [DW-1:0]     cmd,
  output logic              irq,
  output logic [STAT_W-1:0] status
);
  mst_state_e    state_q, state_n;
  logic          req_q, req_n;
  logic [DW-1:0] cmd_q;
  logic          cmd_en;
  logic          irq_q, irq_n;
  logic          done_q, done_n;
  logic          rej_q, rej_n;
  logic          clr;

  assign clr = sense_stb & sense_rst;

  always_comb begin
    state_n = state_q;
    req_n   = req_q;
    irq_n   = irq_q;
    done_n  = done_q;
    rej_n   = rej_q;
    cmd_en  = 1'b0;
    if (clr) begin
      irq_n  = 1'b0;
      done_n = 1'b0;
      rej_n  = 1'b0;
    end
    case (state_q)
      M_IDLE: begin
        if (wr_stb) begin
          cmd_en  = 1'b1;
          req_n   = 1'b1;
          state_n = M_REQ;
        end
      end
      M_REQ: begin
        if (wr_stb) rej_n = 1'b1;
        if (ack_s) begin
          req_n   = 1'b0;
          state_n = M_DROP;
        end
      end
      M_DROP: begin
        if (wr_stb) rej_n = 1'b1;
        if (!ack_s) begin
          irq_n   = 1'b1;
          done_n  = 1'b1;
          state_n = M_IDLE;
        end
      end
      default: begin
        req_n   = 1'b0;
        state_n = M_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      req_q   <= 1'b0;
      irq_q   <= 1'b0;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      req_q   <= req_n;
      irq_q   <= irq_n;
      done_q  <= done_n;
      rej_q   <= rej_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= wr_data;
  end

  always_comb begin
    status          = '0;
    status[DW-1:0]  = cmd_q;
    status[ST_BUSY] = (state_q != M_IDLE);
    status[ST_REJ]  = rej_q;
    status[ST_DONE] = done_q;
  end

  assign req = req_q;
  assign cmd = cmd_q;
  assign irq = irq_q;

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_s) |=> req_q);

  assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == M_REQ && ack_s) |=> !req_q);

  assert_irq_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr) |=> irq_q);

  assert_reject_keeps_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != M_IDLE && wr_stb) |=> (rej_q && $stable(cmd_q)));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == M_DROP && !ack_s) |=> (irq_q && done_q));
endmodule

// File: rtl/pcmd_slave.sv
module pcmd_slave
  import pcmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_s,
  input  logic [DW-1:0] cmd_bus,
  output logic          ack,
  output logic [DW-1:0] perif_cmd
);
  slv_state_e    state_q, state_n;
  logic          ack_q, ack_n;
  logic [DW-1:0] strobe_q, strobe_n;

  always_comb begin
    state_n  = state_q;
    ack_n    = ack_q;
    strobe_n = '0;
    case (state_q)
      S_IDLE: begin
        if (req_s) begin
          strobe_n = cmd_bus;
          state_n  = S_FIRE;
        end
      end
      S_FIRE: begin
        ack_n   = 1'b1;
        state_n = S_ACK;
      end
      S_ACK: begin
        if (!req_s) begin
          ack_n   = 1'b0;
          state_n = S_IDLE;
        end
      end
      default: begin
        ack_n   = 1'b0;
        state_n = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      ack_q    <= 1'b0;
      strobe_q <= '0;
    end else begin
      state_q  <= state_n;
      ack_q    <= ack_n;
      strobe_q <= strobe_n;
    end
  end

  assign ack       = ack_q;
  assign perif_cmd = strobe_q;

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FIRE) |=> (strobe_q == '0));

  assert_ack_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(state_q == S_FIRE));

  assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && req_s) |=> ack_q);

  assert_no_refire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ACK) |=> (strobe_q == '0));
endmodule

// File: rtl/pcmd_link.sv
module pcmd_link
  import pcmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              mst_clk,
  input  logic              mst_arst_n,
  input  logic              slv_clk,
  input  logic              slv_arst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_sense,
  input  logic              host_sense_rst,
  output logic [STAT_W-1:0] dev_status,
  output logic              dev_irq,
  output logic              link_req,
  output logic              link_ack,
  output logic [DATA_W-1:0] perif_cmd
);
  logic              m_rst_n;
  logic              s_rst_n;
  logic              req_w;
  logic              ack_w;
  logic              req_sync;
  logic              ack_sync;
  logic [DATA_W-1:0] cmd_w;

  pcmd_rst_sync #(.STAGES(2)) u_mrst (
    .clk(mst_clk), .arst_n(mst_arst_n), .rst_n(m_rst_n)
  );

  pcmd_rst_sync #(.STAGES(2)) u_srst (
    .clk(slv_clk), .arst_n(slv_arst_n), .rst_n(s_rst_n)
  );

  pcmd_sync2 #(.W(1)) u_ack_sync (
    .clk(mst_clk), .rst_n(m_rst_n), .d(ack_w), .q(ack_sync)
  );

  pcmd_sync2 #(.W(1)) u_req_sync (
    .clk(slv_clk), .rst_n(s_rst_n), .d(req_w), .q(req_sync)
  );

  pcmd_master #(.DW(DATA_W)) u_master (
    .clk       (mst_clk),
    .rst_n     (m_rst_n),
    .wr_stb    (host_wr),
    .wr_data   (host_wr_data),
    .sense_stb (host_sense),
    .sense_rst (host_sense_rst),
    .ack_s     (ack_sync),
    .req       (req_w),
    .cmd       (cmd_w),
    .irq       (dev_irq),
    .status    (dev_status)
  );

  pcmd_slave #(.DW(DATA_W)) u_slave (
    .clk       (slv_clk),
    .rst_n     (s_rst_n),
    .req_s     (req_sync),
    .cmd_bus   (cmd_w),
    .ack       (ack_w),
    .perif_cmd (perif_cmd)
  );

  assign link_req = req_w;
  assign link_ack = ack_w;
endmodule

// File: tb/pcmd_link_bench.sv
module pcmd_link_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;

  logic          clk;
  logic          arst_n;
  logic          host_wr;
  logic [DW-1:0] host_wr_data;
  logic          host_sense;
  logic          host_sense_rst;
  logic [15:0]   dev_status;
  logic          dev_irq;
  logic          link_req;
  logic          link_ack;
  logic [DW-1:0] perif_cmd;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  int strobe_cnt  = 0;
  int strobe_wide = 0;
  int strobe_late = 0;
  logic [DW-1:0] last_strobe = '0;
  logic [DW-1:0] prev_strobe = '0;
  logic mon_en = 1'b0;

  logic         exp_irq, exp_done, exp_rej;
  logic [DW-1:0] exp_data;

  pcmd_link #(.DATA_W(DW)) u_pcmd_link (
    .mst_clk(clk), .mst_arst_n(arst_n), .slv_clk(clk), .slv_arst_n(arst_n),
    .host_wr(host_wr), .host_wr_data(host_wr_data),
    .host_sense(host_sense), .host_sense_rst(host_sense_rst),
    .dev_status(dev_status), .dev_irq(dev_irq),
    .link_req(link_req), .link_ack(link_ack), .perif_cmd(perif_cmd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired: actual=%0d cycles expected<=100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (perif_cmd != '0) begin
        strobe_cnt++;
        last_strobe = perif_cmd;
        if (prev_strobe != '0) strobe_wide++;
        if (link_ack) strobe_late++;
      end
      prev_strobe = perif_cmd;
    end
  end

  function automatic logic [15:0] model_status();
    logic [15:0] s;
    s = '0;
    s[7:0] = exp_data;
    s[15]  = exp_done;
    s[14]  = exp_rej;
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sense(input logic rbit, input logic with_wr, input logic [DW-1:0] wd);
    @(negedge clk);
    host_sense = 1'b1; host_sense_rst = rbit;
    if (with_wr) begin host_wr = 1'b1; host_wr_data = wd; end
    @(negedge clk);
    host_sense = 1'b0; host_sense_rst = 1'b0; host_wr = 1'b0;
  endtask

  // busy_mode: 0 none, 1 lone busy write, 2 busy write with sense-reset in same clock
  task automatic run_txn(input logic [DW-1:0] d, input int busy_mode, input logic collide,
                         input int sense_mode);
    int  sc0;
    bit  held;
    int  t;
    sc0 = strobe_cnt;
    @(negedge clk);
    host_wr = 1'b1; host_wr_data = d;
    @(negedge clk);
    host_wr = 1'b0;
    exp_data = d;
    chk("R2 link_req after write", {31'b0, link_req}, 32'd1);
    chk("R2 busy bit", {31'b0, dev_status[13]}, 32'd1);
    chk("R2 data latched", {24'b0, dev_status[7:0]}, {24'b0, d});
    if (busy_mode != 0) begin
      host_wr = 1'b1; host_wr_data = ~d;
      if (busy_mode == 2) begin host_sense = 1'b1; host_sense_rst = 1'b1; end
      @(negedge clk);
      host_wr = 1'b0; host_sense = 1'b0; host_sense_rst = 1'b0;
      exp_rej = 1'b1;
      if (busy_mode == 2) begin
        exp_irq = 1'b0; exp_done = 1'b0;
        chk("R8 reject beats clear", {31'b0, dev_status[14]}, 32'd1);
        chk("R8 irq cleared alongside", {31'b0, dev_irq}, 32'd0);
      end
      chk("R7 reject set", {31'b0, dev_status[14]}, 32'd1);
      chk("R7 data unchanged", {24'b0, dev_status[7:0]}, {24'b0, d});
    end
    held = 1'b1;
    t = 0;
    while (!link_ack && t < 60) begin
      if (!link_req) held = 1'b0;
      @(negedge clk); t++;
    end
    chk("R2 req held until ack", {31'b0, held}, 32'd1);
    chk("R4 req high when ack rises", {31'b0, link_req}, 32'd1);
    t = 0;
    while (link_ack && t < 60) begin @(negedge clk); t++; end
    chk("R4 req low before ack falls", {31'b0, link_req}, 32'd0);
    if (collide) begin
      @(negedge clk);
      @(negedge clk);
      host_sense = 1'b1; host_sense_rst = 1'b1;
      @(negedge clk);
      host_sense = 1'b0; host_sense_rst = 1'b0;
      exp_irq = 1'b1; exp_done = 1'b1; exp_rej = 1'b0;
      chk("R8 irq set beats clear", {31'b0, dev_irq}, 32'd1);
      chk("R8 done set beats clear", {31'b0, dev_status[15]}, 32'd1);
    end
    t = 0;
    while (dev_status[13] && t < 60) begin @(negedge clk); t++; end
    if (!collide) begin exp_irq = 1'b1; exp_done = 1'b1; end
    chk("R5 irq on completion", {31'b0, dev_irq}, {31'b0, exp_irq});
    chk("R5 status after completion", {16'b0, dev_status}, {16'b0, model_status()});
    chk("R3 one strobe per write", strobe_cnt, sc0 + 1);
    chk("R3 strobe value", {24'b0, last_strobe}, {24'b0, d});
    if (sense_mode != 0) begin
      sense(sense_mode == 2, 1'b0, '0);
      if (sense_mode == 2) begin exp_irq = 1'b0; exp_done = 1'b0; exp_rej = 1'b0; end
      chk("R6 irq after sense", {31'b0, dev_irq}, {31'b0, exp_irq});
      chk("R6 status after sense", {16'b0, dev_status}, {16'b0, model_status()});
    end
  endtask

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd24681));
    arst_n = 1'b0; host_wr = 1'b0; host_wr_data = '0;
    host_sense = 1'b0; host_sense_rst = 1'b0;
    exp_irq = 1'b0; exp_done = 1'b0; exp_rej = 1'b0; exp_data = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 link_req reset", {31'b0, link_req}, 32'd0);
    chk("R1 link_ack reset", {31'b0, link_ack}, 32'd0);
    chk("R1 irq reset", {31'b0, dev_irq}, 32'd0);
    chk("R1 status reset", {16'b0, dev_status}, 32'd0);
    chk("R1 perif reset", {24'b0, perif_cmd}, 32'd0);
    mon_en = 1'b1;

    run_txn(8'h01, 0, 1'b0, 1);
    run_txn(8'h80, 1, 1'b0, 1);
    run_txn(8'hFF, 0, 1'b0, 2);
    run_txn(8'h3C, 2, 1'b0, 0);
    run_txn(8'hA5, 0, 1'b1, 0);
    run_txn(8'h5A, 1, 1'b1, 2);

    for (int i = 0; i < 40; i++) begin
      d = DW'($urandom);
      if (d == '0) d = 8'h69;
      run_txn(d, int'($urandom % 3), ($urandom % 4) == 0, int'($urandom % 3));
    end

    chk("R3 strobe one clock wide", strobe_wide, 0);
    chk("R3 strobe before ack", strobe_late, 0);
    repeat (5) @(negedge clk);
    chk("R7 no stray strobe when idle", {24'b0, perif_cmd}, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule